// File: doc/BRIEF.md
# Endpoint Bank Handshake Controller

This block keeps track of the data banks of one device-side USB endpoint that has one, two or three banks. The firmware always works on one bank, the current bank. The packet engine works on the oldest bank that holds data. The block presents two firmware flags for the current bank: an interrupt flag and an ownership flag. The interrupt flag reads "bank free" on an IN endpoint and "OUT data received" on an OUT endpoint. Firmware first acknowledges the interrupt flag. It then clears ownership to hand the bank over. The block then moves to the next bank and reloads both flags from that bank's state.

The direction and the bank count are configuration inputs, latched while reset is held. A bank count of 0 is taken as 1. Toward the packet engine there are two streams. The IN stream offers filled banks for transmission with `tx_valid`, and `tx_ready` completes the oldest one. The OUT stream accepts received packets with `rx_valid`/`rx_ready`. A transfer happens in a cycle where both valid and ready are 1. The OUT stream does not stall the engine. An `rx_valid` that arrives while `rx_ready` is 0 is dropped, not held, and `ovf_pulse` reports it for one cycle. Control inputs are single-cycle strobes. Status outputs are plain levels.

Top module: `ep_bank_ctrl`

## Requirements
- R1: While `rst_n` is 0 (synchronous), direction and bank count are latched, and `cur_bank`, `busy_banks`, all flags, the enables, `irq` and `ovf_pulse` are 0.
- R2: On an IN endpoint, `own_flag` is 1 exactly when `busy_banks` is below the bank count. `free_flag` is set in the cycle where the firmware gains a bank. `free_flag` is always 0 on an OUT endpoint.
- R3: `irq` is (`free_flag` AND enable bit 0) OR (`rxd_flag` AND enable bit 1). A 1 on `cpu_ie_set[k]` sets enable k and a 1 on `cpu_ie_clr[k]` clears it. Set wins when both are 1.
- R4: `cpu_flag_clr[0]` clears `free_flag` and `cpu_flag_clr[1]` clears `rxd_flag`. Neither touches the ownership flag, the bank index or the busy count.
- R5: `cpu_own_clr` is ignored unless `own_flag` is 1 and the direction's interrupt flag is already 0. This holds even when that flag is cleared in the same cycle.
- R6: An accepted release advances `cur_bank` by one, wrapping from count-1 to 0. On the next cycle both flags show the state of the new current bank.
- R7: IN stream: `tx_valid` is 1 when `busy_banks` > 0. `tx_bank` and `tx_bytes` name the oldest released bank and the byte count that `cpu_bytes` gave it at release. `tx_ready` with `tx_valid` frees that bank. If the firmware was waiting, its flags set on the next cycle.
- R8: OUT stream: `rx_ready` is 1 when `busy_banks` is below the bank count. An accepted `rx_valid` stores `rx_bytes` into bank `rx_bank`. An `rx_valid` while `rx_ready` is 0 is dropped and gives `ovf_pulse` = 1 for one cycle. `cur_bytes` shows the current bank's stored count.
- R9: `busy_banks` never exceeds the latched bank count. A configured count of 0 behaves as 1.
- R10: Stream inputs of the other direction (`rx_valid` on IN, `tx_ready` on OUT) have no effect.
- R11: On an OUT endpoint, `own_flag` is 1 exactly when `busy_banks` > 0. `rxd_flag` sets when the current bank gains a received packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_is_in | input | 1 | 1 = IN endpoint, latched in reset |
| cfg_banks | input | 2 | Bank count 1..3 (0 means 1), latched in reset |
| cpu_flag_clr | input | 2 | Interrupt-flag clear strobes: bit 0 bank free, bit 1 OUT received |
| cpu_ie_set | input | 2 | Enable set strobes, same bit order |
| cpu_ie_clr | input | 2 | Enable clear strobes, same bit order |
| cpu_own_clr | input | 1 | Release current bank |
| cpu_bytes | input | 11 | Byte count stored with an IN bank at release |
| tx_valid | output | 1 | A released IN bank awaits sending |
| tx_ready | input | 1 | Engine finished sending the offered bank |
| tx_bank | output | 2 | Index of the offered IN bank |
| tx_bytes | output | 11 | Byte count of the offered IN bank |
| rx_valid | input | 1 | Engine delivers a received OUT packet |
| rx_ready | output | 1 | A free OUT bank exists |
| rx_bank | output | 2 | Bank the next OUT packet goes to |
| rx_bytes | input | 11 | Byte count of the delivered OUT packet |
| cur_bank | output | 2 | Current firmware bank index |
| busy_banks | output | 2 | Banks holding data in flight |
| cur_bytes | output | 11 | Stored byte count of the current bank |
| own_flag | output | 1 | Firmware owns the current bank |
| free_flag | output | 1 | Bank-free interrupt flag (IN) |
| rxd_flag | output | 1 | OUT-received interrupt flag |
| irq | output | 1 | Endpoint interrupt |
| ovf_pulse | output | 1 | One-cycle dropped-packet indication |

## Verification
A wrong bank pointer or busy count in this block shows at the ports within one cycle of the event that corrupts it. It appears as a bad `cur_bank`, `busy_banks`, `tx_bank` or `rx_bank`, or as a stream valid/ready level that disagrees with the count. A stale flag register shows at once in `own_flag`, `free_flag`, `rxd_flag` or `irq`. A lost or misplaced byte count is only visible later, when that bank becomes the oldest: in `tx_bytes` on IN, in `cur_bytes` on OUT. The bench therefore compares every output on every clock against a queue-based model. The model runs long random strobe mixes in both directions and at every bank count.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;
  // bit positions of the per-direction interrupt flag, enable and clear strobes
  localparam int FLG_FREE = 0;
  localparam int FLG_RXD  = 1;
  localparam int NFLG     = 2;

  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } ep_dir_e;
endpackage

// File: rtl/ep_bank_ring.sv
module ep_bank_ring #(
  parameter int MAX_BANKS = 3,
  parameter int BYTES_W   = 11,
  localparam int CNT_W = $clog2(MAX_BANKS + 1),
  localparam int PTR_W = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ep_bank_pkg::ep_dir_e dir,
  input  logic [CNT_W-1:0]   nb,
  input  logic               cpu_rel,
  input  logic [BYTES_W-1:0] cpu_bytes,
  input  logic               eng_xfer,
  input  logic [BYTES_W-1:0] eng_bytes,
  output logic [PTR_W-1:0]   cur,
  output logic [PTR_W-1:0]   eptr,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   cnt_nxt,
  output logic [BYTES_W-1:0] cur_bytes,
  output logic [BYTES_W-1:0] eptr_bytes
);
  import ep_bank_pkg::*;

  logic [BYTES_W-1:0] mem [MAX_BANKS];
  logic               inc, dec, wr_en;
  logic [PTR_W-1:0]   wr_idx;
  logic [BYTES_W-1:0] wr_data;
  logic               cur_step, eptr_step;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p,
                                           input logic [CNT_W-1:0] n);
    logic [CNT_W:0] s;
    s = {{(CNT_W + 1 - PTR_W){1'b0}}, p} + 1'b1;
    return (s >= {1'b0, n}) ? '0 : PTR_W'(s);
  endfunction

  always_comb begin
    if (dir == DIR_IN) begin
      inc     = cpu_rel;
      dec     = eng_xfer;
      wr_en   = cpu_rel;
      wr_idx  = cur;
      wr_data = cpu_bytes;
    end else begin
      inc     = eng_xfer;
      dec     = cpu_rel;
      wr_en   = eng_xfer;
      wr_idx  = eptr;
      wr_data = eng_bytes;
    end
    cur_step  = cpu_rel;
    eptr_step = eng_xfer;
    cnt_nxt   = cnt + CNT_W'(inc) - CNT_W'(dec);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur  <= '0;
      eptr <= '0;
      cnt  <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (cur_step)  cur  <= adv(cur, nb);
      if (eptr_step) eptr <= adv(eptr, nb);
    end
  end

  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                               mem[b] <= '0;
      else if (wr_en && (wr_idx == PTR_W'(b)))  mem[b] <= wr_data;
    end
  end

  assign cur_bytes  = mem[cur];
  assign eptr_bytes = mem[eptr];
endmodule

// File: rtl/ep_bank_flags.sv
module ep_bank_flags #(
  parameter int MAX_BANKS = 3,
  localparam int CNT_W = $clog2(MAX_BANKS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  ep_bank_pkg::ep_dir_e          dir,
  input  logic [CNT_W-1:0]              nb,
  input  logic [CNT_W-1:0]              cnt_nxt,
  input  logic                          rel_ok,
  input  logic [ep_bank_pkg::NFLG-1:0]  flag_clr,
  input  logic [ep_bank_pkg::NFLG-1:0]  ie_set,
  input  logic [ep_bank_pkg::NFLG-1:0]  ie_clr,
  output logic                          own,
  output logic [ep_bank_pkg::NFLG-1:0]  flg,
  output logic                          irq
);
  import ep_bank_pkg::*;

  logic [NFLG-1:0] ie;
  logic [NFLG-1:0] flg_nxt;
  logic [NFLG-1:0] dir_sel;
  logic            avail_nxt, arm;

  always_comb begin
    avail_nxt = (dir == DIR_IN) ? (cnt_nxt < nb) : (cnt_nxt != '0);
    // the firmware gains a bank it did not hold before (or just released one)
    arm       = avail_nxt && (!own || rel_ok);
    dir_sel   = '0;
    dir_sel[(dir == DIR_IN) ? FLG_FREE : FLG_RXD] = 1'b1;
  end

  for (genvar k = 0; k < NFLG; k++) begin : g_flag
    assign flg_nxt[k] = dir_sel[k] && (arm || (flg[k] && !flag_clr[k]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own <= 1'b0;
      flg <= '0;
      ie  <= '0;
    end else begin
      own <= avail_nxt;
      flg <= flg_nxt;
      ie  <= (ie & ~ie_clr) | ie_set;
    end
  end

  assign irq = |(flg & ie);
endmodule

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl #(
  parameter int MAX_BANKS = 3,
  parameter int BYTES_W   = 11,
  localparam int CNT_W = $clog2(MAX_BANKS + 1),
  localparam int PTR_W = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_is_in,
  input  logic [CNT_W-1:0]   cfg_banks,
  input  logic [1:0]         cpu_flag_clr,
  input  logic [1:0]         cpu_ie_set,
  input  logic [1:0]         cpu_ie_clr,
  input  logic               cpu_own_clr,
  input  logic [BYTES_W-1:0] cpu_bytes,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [PTR_W-1:0]   tx_bank,
  output logic [BYTES_W-1:0] tx_bytes,
  input  logic               rx_valid,
  output logic               rx_ready,
  output logic [PTR_W-1:0]   rx_bank,
  input  logic [BYTES_W-1:0] rx_bytes,
  output logic [PTR_W-1:0]   cur_bank,
  output logic [CNT_W-1:0]   busy_banks,
  output logic [BYTES_W-1:0] cur_bytes,
  output logic               own_flag,
  output logic               free_flag,
  output logic               rxd_flag,
  output logic               irq,
  output logic               ovf_pulse
);
  import ep_bank_pkg::*;

  ep_dir_e          dir_q;
  logic [CNT_W-1:0] nb_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [PTR_W-1:0] eptr;
  logic [BYTES_W-1:0] eptr_bytes;
  logic [NFLG-1:0]  flg;
  logic             act_flag, rel_ok, eng_xfer, drop;

  // configuration latched while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= cfg_is_in ? DIR_IN : DIR_OUT;
      if (cfg_banks == '0)                        nb_q <= CNT_W'(1);
      else if (cfg_banks > CNT_W'(MAX_BANKS))     nb_q <= CNT_W'(MAX_BANKS);
      else                                        nb_q <= cfg_banks;
    end
  end

  assign tx_valid = (dir_q == DIR_IN)  && (busy_banks != '0);
  assign rx_ready = (dir_q == DIR_OUT) && (busy_banks < nb_q);
  assign act_flag = (dir_q == DIR_IN) ? flg[FLG_FREE] : flg[FLG_RXD];
  assign rel_ok   = cpu_own_clr && own_flag && !act_flag;
  assign eng_xfer = (tx_valid && tx_ready) || (rx_valid && rx_ready);
  assign drop     = (dir_q == DIR_OUT) && rx_valid && !rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_pulse <= 1'b0;
    else        ovf_pulse <= drop;
  end

  ep_bank_ring #(.MAX_BANKS(MAX_BANKS), .BYTES_W(BYTES_W)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir        (dir_q),
    .nb         (nb_q),
    .cpu_rel    (rel_ok),
    .cpu_bytes  (cpu_bytes),
    .eng_xfer   (eng_xfer),
    .eng_bytes  (rx_bytes),
    .cur        (cur_bank),
    .eptr       (eptr),
    .cnt        (busy_banks),
    .cnt_nxt    (cnt_nxt),
    .cur_bytes  (cur_bytes),
    .eptr_bytes (eptr_bytes)
  );

  ep_bank_flags #(.MAX_BANKS(MAX_BANKS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir      (dir_q),
    .nb       (nb_q),
    .cnt_nxt  (cnt_nxt),
    .rel_ok   (rel_ok),
    .flag_clr (cpu_flag_clr),
    .ie_set   (cpu_ie_set),
    .ie_clr   (cpu_ie_clr),
    .own      (own_flag),
    .flg      (flg),
    .irq      (irq)
  );

  assign tx_bank   = eptr;
  assign tx_bytes  = eptr_bytes;
  assign rx_bank   = eptr;
  assign free_flag = flg[FLG_FREE];
  assign rxd_flag  = flg[FLG_RXD];
endmodule

// File: rtl/ep_bank_ctrl_chk.sv
module ep_bank_ctrl_chk #(
  parameter int MAX_BANKS = 3,
  localparam int CNT_W = $clog2(MAX_BANKS + 1),
  localparam int PTR_W = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             is_in,
  input logic [CNT_W-1:0] nb,
  input logic             cpu_own_clr,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [CNT_W-1:0] busy_banks,
  input logic [PTR_W-1:0] cur_bank,
  input logic             own_flag,
  input logic             free_flag,
  input logic             rxd_flag,
  input logic             irq,
  input logic             ovf_pulse
);
  a_r9_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> busy_banks <= nb);

  a_r2_out_no_free: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !is_in |-> !free_flag);

  a_r2_own_in: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && is_in |-> own_flag == (busy_banks < nb));

  a_r11_own_out: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !is_in |-> own_flag == (busy_banks != '0));

  a_r5_blocked_release: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && cpu_own_clr && (is_in ? free_flag : rxd_flag) |=> $stable(cur_bank));

  a_r3_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (free_flag || rxd_flag));

  a_r7_ack_frees: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !cpu_own_clr |=> busy_banks == $past(busy_banks) - 1'b1);

  a_r8_fill_takes: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !cpu_own_clr |=> busy_banks == $past(busy_banks) + 1'b1);

  a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ovf_pulse |-> $past(rx_valid && !rx_ready && !is_in));
endmodule

bind ep_bank_ctrl ep_bank_ctrl_chk #(.MAX_BANKS(MAX_BANKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .is_in       (dir_q == ep_bank_pkg::DIR_IN),
  .nb          (nb_q),
  .cpu_own_clr (cpu_own_clr),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .busy_banks  (busy_banks),
  .cur_bank    (cur_bank),
  .own_flag    (own_flag),
  .free_flag   (free_flag),
  .rxd_flag    (rxd_flag),
  .irq         (irq),
  .ovf_pulse   (ovf_pulse)
);

// File: tb/ep_bank_ctrl_test.sv
module ep_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_is_in = 1'b1;
  logic [1:0]  cfg_banks = 2'd2;
  logic [1:0]  cpu_flag_clr = '0, cpu_ie_set = '0, cpu_ie_clr = '0;
  logic        cpu_own_clr = 1'b0;
  logic [10:0] cpu_bytes = '0, rx_bytes = '0;
  logic        tx_ready = 1'b0, rx_valid = 1'b0;
  logic        tx_valid, rx_ready, own_flag, free_flag, rxd_flag, irq, ovf_pulse;
  logic [1:0]  tx_bank, rx_bank, cur_bank, busy_banks;
  logic [10:0] tx_bytes, cur_bytes;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // reference model state
  int m_nb, m_in, m_cnt, m_cur, m_ep, m_own, m_ftx, m_frx, m_ovf;
  int m_ie0, m_ie1;
  int q[$];

  always #5 clk = ~clk;

  ep_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_is_in(cfg_is_in), .cfg_banks(cfg_banks),
    .cpu_flag_clr(cpu_flag_clr), .cpu_ie_set(cpu_ie_set), .cpu_ie_clr(cpu_ie_clr),
    .cpu_own_clr(cpu_own_clr), .cpu_bytes(cpu_bytes),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_bank(tx_bank), .tx_bytes(tx_bytes),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_bank(rx_bank), .rx_bytes(rx_bytes),
    .cur_bank(cur_bank), .busy_banks(busy_banks), .cur_bytes(cur_bytes),
    .own_flag(own_flag), .free_flag(free_flag), .rxd_flag(rxd_flag),
    .irq(irq), .ovf_pulse(ovf_pulse)
  );

  task automatic chk(input string req, input string nm, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp);
    end
  endtask

  function automatic int nxt(input int p);
    return (p + 1 >= m_nb) ? 0 : p + 1;
  endfunction

  task automatic model_step();
    int act, rel, cnt_n, avail, arm;
    if (!rst_n) begin
      m_nb = (cfg_banks == 0) ? 1 : int'(cfg_banks);
      m_in = int'(cfg_is_in);
      m_cnt = 0; m_cur = 0; m_ep = 0; m_own = 0; m_ftx = 0; m_frx = 0;
      m_ovf = 0; m_ie0 = 0; m_ie1 = 0;
      q.delete();
      return;
    end
    act = m_in ? m_ftx : m_frx;
    rel = (cpu_own_clr && m_own && !act) ? 1 : 0;
    cnt_n = m_cnt;
    m_ovf = 0;
    if (m_in) begin
      if (tx_ready && m_cnt > 0) begin
        void'(q.pop_front()); cnt_n--; m_ep = nxt(m_ep);
      end
      if (rel) begin
        q.push_back(int'(cpu_bytes)); cnt_n++; m_cur = nxt(m_cur);
      end
    end else begin
      if (rx_valid) begin
        if (m_cnt < m_nb) begin
          q.push_back(int'(rx_bytes)); cnt_n++; m_ep = nxt(m_ep);
        end else m_ovf = 1;
      end
      if (rel) begin
        void'(q.pop_front()); cnt_n--; m_cur = nxt(m_cur);
      end
    end
    avail = m_in ? (cnt_n < m_nb) : (cnt_n > 0);
    arm = avail && (!m_own || rel);
    m_ftx = m_in  && (arm || (m_ftx && !cpu_flag_clr[0]));
    m_frx = !m_in && (arm || (m_frx && !cpu_flag_clr[1]));
    m_own = avail;
    m_cnt = cnt_n;
    m_ie0 = cpu_ie_set[0] ? 1 : (cpu_ie_clr[0] ? 0 : m_ie0);
    m_ie1 = cpu_ie_set[1] ? 1 : (cpu_ie_clr[1] ? 0 : m_ie1);
  endtask

  task automatic compare();
    chk("R6", "cur_bank", int'(cur_bank), m_cur);
    chk("R9", "busy_banks", int'(busy_banks), m_cnt);
    chk("R2", "own_flag", int'(own_flag), m_own);
    chk("R2", "free_flag", int'(free_flag), m_ftx);
    chk("R11", "rxd_flag", int'(rxd_flag), m_frx);
    chk("R3", "irq", int'(irq), (m_ftx && m_ie0) || (m_frx && m_ie1));
    chk("R8", "ovf_pulse", int'(ovf_pulse), m_ovf);
    chk("R8", "rx_ready", int'(rx_ready), (!m_in && m_cnt < m_nb) ? 1 : 0);
    chk("R7", "tx_valid", int'(tx_valid), (m_in && m_cnt > 0) ? 1 : 0);
    if (m_in && m_cnt > 0) begin
      chk("R7", "tx_bank", int'(tx_bank), m_ep);
      chk("R7", "tx_bytes", int'(tx_bytes), q[0]);
    end
    if (!m_in) chk("R8", "rx_bank", int'(rx_bank), m_ep);
    if (!m_in && m_cnt > 0) chk("R8", "cur_bytes", int'(cur_bytes), q[0]);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (rst_n) compare();
    cpu_flag_clr = '0; cpu_ie_set = '0; cpu_ie_clr = '0; cpu_own_clr = 1'b0;
    tx_ready = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic do_reset(input logic is_in, input logic [1:0] nb);
    rst_n = 1'b0; cfg_is_in = is_in; cfg_banks = nb;
    repeat (3) cyc();
    chk("R1", "reset own", int'(own_flag), 0);
    chk("R1", "reset busy", int'(busy_banks), 0);
    chk("R1", "reset irq", int'(irq), 0);
    chk("R1", "reset cur", int'(cur_bank), 0);
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic release_bank(input int bytes);
    cpu_flag_clr = 2'b11; cyc();
    cpu_own_clr = 1'b1; cpu_bytes = 11'(bytes); cyc();
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      cpu_flag_clr = 2'($urandom);
      cpu_own_clr  = ($urandom % 2) == 0;
      cpu_ie_set   = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      cpu_ie_clr   = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      cpu_bytes    = 11'($urandom);
      rx_bytes     = 11'($urandom);
      tx_ready     = ($urandom % 3) == 0;
      rx_valid     = ($urandom % 3) == 0;
      cyc();
    end
  endtask

  initial begin
    int b0;
    // IN endpoint, two banks
    do_reset(1'b1, 2'd2);
    cpu_ie_set = 2'b01; cyc();
    chk("R2", "in free after reset", int'(free_flag), 1);
    cpu_own_clr = 1'b1; cyc();
    chk("R5", "release ignored with flag set", int'(cur_bank), 0);
    cpu_flag_clr = 2'b01; cyc();
    chk("R4", "clear keeps own", int'(own_flag), 1);
    chk("R4", "clear keeps busy", int'(busy_banks), 0);
    rx_valid = 1'b1; cyc();
    chk("R10", "rx ignored on IN", int'(busy_banks), 0);
    cpu_own_clr = 1'b1; cpu_bytes = 11'd10; cyc();
    chk("R6", "advance to bank 1", int'(cur_bank), 1);
    release_bank(20);
    chk("R9", "full at two", int'(busy_banks), 2);
    chk("R6", "wrap to bank 0", int'(cur_bank), 0);
    tx_ready = 1'b1; cyc();
    chk("R7", "freed bank gives flag", int'(free_flag), 1);
    cpu_flag_clr = 2'b01; cyc();
    cpu_own_clr = 1'b1; tx_ready = 1'b1; cpu_bytes = 11'd33; cyc();
    random_run(3000);

    // OUT endpoint, three banks
    do_reset(1'b0, 2'd3);
    cpu_ie_set = 2'b10; cyc();
    for (int i = 0; i < 4; i++) begin
      rx_valid = 1'b1; rx_bytes = 11'(100 + i); cyc();
    end
    chk("R8", "fourth packet dropped", int'(ovf_pulse), 1);
    chk("R9", "busy saturates", int'(busy_banks), 3);
    tx_ready = 1'b1; cyc();
    chk("R10", "tx_ready ignored on OUT", int'(busy_banks), 3);
    b0 = int'(cur_bytes);
    chk("R8", "first bank bytes", b0, 100);
    release_bank(0);
    chk("R11", "next bank flagged", int'(rxd_flag), 1);
    rx_valid = 1'b1; rx_bytes = 11'd7; cpu_own_clr = 1'b1; cyc();
    random_run(3000);

    // one bank, and a zero setting treated as one
    do_reset(1'b1, 2'd0);
    release_bank(5);
    chk("R9", "zero means one bank", int'(busy_banks), 1);
    chk("R6", "single bank stays 0", int'(cur_bank), 0);
    random_run(1500);
    do_reset(1'b0, 2'd1);
    random_run(1500);
    do_reset(1'b1, 2'd3);
    random_run(2000);
    do_reset(1'b0, 2'd2);
    random_run(2000);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog run did not complete");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule